// File: doc/BRIEF.md
# Clock Output Stop Controller

This block sits between a bank of already generated lane clocks and the output pads. For every lane it decides whether the clock is passed through, held low, parked at a static driven level, or released to high impedance. It reports that decision as a 2-bit drive-state code, which the pad logic uses to choose between toggling, driving a level and floating.

Three things feed that decision:
- An active-low bus-clock stop pin and a software stop-control bit together form a stop request. That request reaches only the lanes that are allowed to stop.
- An active-low power-down pin acts at once, with no clock edge needed, and overrides everything else.
- Per-lane configuration inputs:
  - an output enable;
  - a stoppable flag for the optional lanes;
  - tristate-on-stop and tristate-on-power-down choices.

Each lane passes its stop request through a synchronizer clocked by that lane's own clock. It changes its gate only while its clock is low, so a lane never emits a shortened high pulse.

With the default parameters there are 16 lanes, in index order:
- 0 to 6: bus clock lanes;
- 7 to 9: free-running bus clock lanes;
- 10: the serial reference lane;
- 11 to 13: processor lanes;
- 14 and 15: other lanes.

Drive codes are packed two bits per lane, with lane i in bits [2i+1:2i].

Top module: `clk_stop_ctrl`

## Requirements
- R1: A stop request is formed when `pci_stop_n` is 0 with `stop_pin_mask` 0. While it is present, every bus clock lane (indices 0 to 6) holds its clock low and reports code 01. The stop takes effect at the first falling edge that follows the second rising edge of that lane's clock after the request.
- R2: A free-running bus clock lane (indices 7 to 9) ignores the stop request while its `lane_stoppable` bit is 0. With the bit at 1, it stops low with code 01.
- R3: The serial reference lane (index 10) follows the stop request only when its `lane_stoppable` bit is 1. When stopped, it reports 10 (driven static) if its `stop_tri` bit is 0, and 11 (tristate) if that bit is 1. Its clock is low in both cases.
- R4: `sw_stop_ctl` at 0 forms the same stop request as the pin, whatever the pin level or mask.
- R5: `stop_pin_mask` at 1 makes the stop pin have no effect. `pd_pin_mask` at 1 makes the power-down pin have no effect.
- R6: While `pwr_dn_n` is 0 with `pd_pin_mask` 0, every lane clock output is low at once, without waiting for a clock edge. Processor lanes and the serial reference lane report 10, or 11 when their `pd_tri` bit is 1. All other lanes report 01.
- R7: A lane whose `lane_oe` bit is 0 reports 11 and holds its clock low. The enable passes through the same synchronizer as the stop request.
- R8: A lane's clock output only ever stops during the low phase of that lane's clock, and it restarts on a rising edge. Every high pulse is a full high phase of the lane clock. While the output is high, the lane reports 00.
- R9: Processor and other lanes (indices 11 to 15) never respond to the stop request.
- R10: After reset, every lane runs and reports 00 (drive codes: 00 running, 01 stopped low, 10 driven static, 11 tristate).
- R11: Power-down takes precedence over a disabled output, and a disabled output takes precedence over a stop. Bus clock, free-running bus clock and other lanes never report 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Synchronous active-high reset, applied in each lane's clock domain |
| lane_clk_i | input | 16 | Ungated clock of each lane |
| pci_stop_n | input | 1 | Active-low bus clock stop pin |
| pwr_dn_n | input | 1 | Active-low power-down pin, acts asynchronously |
| sw_stop_ctl | input | 1 | Software stop control; 0 requests a stop |
| stop_pin_mask | input | 1 | 1 masks the stop pin |
| pd_pin_mask | input | 1 | 1 masks the power-down pin |
| lane_oe | input | 16 | Per-lane output enable |
| lane_stoppable | input | 16 | Lets a free-running bus lane or the reference lane follow the stop request |
| stop_tri | input | 16 | Tristate instead of driven static when stopped (reference lane) |
| pd_tri | input | 16 | Tristate instead of driven static in power-down (processor and reference lanes) |
| lane_clk_o | output | 16 | Gated lane clocks |
| lane_drive_o | output | 32 | Two-bit drive code per lane |

## Verification
A stop, restart or enable change passes through two rising edges and then the following falling edge of the lane's own clock. The slowest lane clock in the bench has a 14 ns period, so that is at most about 42 ns. The driver therefore waits 12 bench cycles (96 ns) after each change before it pushes the expected codes and clock activity. The monitor then compares the codes and looks for clock activity over a further 64 ns. A power-down is due with no clock edge at all, so its codes and gated clocks are checked 1 ns after the pin changes. A width monitor on lane 0 checks, across every stop and restart, that no high pulse is shorter than the lane's high phase.

// File: rtl/clk_stop_pkg.sv
`timescale 1ns/1ps
package clk_stop_pkg;

  typedef enum logic [2:0] {
    LK_PCI  = 3'd0,
    LK_PCIF = 3'd1,
    LK_SRC  = 3'd2,
    LK_CPU  = 3'd3,
    LK_AUX  = 3'd4
  } lane_kind_e;

  typedef enum logic [1:0] {
    DRV_RUN    = 2'b00,
    DRV_LOW    = 2'b01,
    DRV_STATIC = 2'b10,
    DRV_TRI    = 2'b11
  } drive_e;

  // Lane order: bus, free-running bus, one reference lane, processor, other.
  function automatic lane_kind_e kind_of(input int idx, input int n_pci,
                                         input int n_pcif, input int n_cpu);
    if (idx < n_pci) return LK_PCI;
    else if (idx < n_pci + n_pcif) return LK_PCIF;
    else if (idx == n_pci + n_pcif) return LK_SRC;
    else if (idx < n_pci + n_pcif + 1 + n_cpu) return LK_CPU;
    else return LK_AUX;
  endfunction

endpackage

// File: rtl/clk_stop_req.sv
`timescale 1ns/1ps
module clk_stop_req
  import clk_stop_pkg::*;
#(
  parameter int N_PCI  = 7,
  parameter int N_PCIF = 3,
  parameter int N_CPU  = 3,
  parameter int N_AUX  = 2,
  localparam int NL    = N_PCI + N_PCIF + 1 + N_CPU + N_AUX
) (
  input  logic          pci_stop_n,
  input  logic          sw_stop_ctl,
  input  logic          stop_pin_mask,
  input  logic          pwr_dn_n,
  input  logic          pd_pin_mask,
  input  logic [NL-1:0] lane_stoppable,
  output logic [NL-1:0] lane_stop,
  output logic          pd_active
);

  logic stop_any;

  assign stop_any  = (~pci_stop_n & ~stop_pin_mask) | ~sw_stop_ctl;
  assign pd_active = ~pwr_dn_n & ~pd_pin_mask;

  for (genvar i = 0; i < NL; i++) begin : g_lane
    localparam lane_kind_e K   = kind_of(i, N_PCI, N_PCIF, N_CPU);
    localparam bit         ALW = (K == LK_PCI);
    localparam bit         OPT = (K == LK_PCIF) || (K == LK_SRC);
    assign lane_stop[i] = stop_any & (ALW | (OPT & lane_stoppable[i]));
  end

endmodule

// File: rtl/clk_stop_lane.sv
`timescale 1ns/1ps
module clk_stop_lane
  import clk_stop_pkg::*;
#(
  parameter lane_kind_e KIND = LK_PCI
) (
  input  logic       clk_i,
  input  logic       rst,
  input  logic       stop_req,
  input  logic       oe,
  input  logic       stop_tri,
  input  logic       pd_tri,
  input  logic       pd_active,
  output logic       clk_o,
  output logic [1:0] drive_o
);

  localparam bit HAS_PD_TRI   = (KIND == LK_CPU) || (KIND == LK_SRC);
  localparam bit HAS_STATIC_S = (KIND == LK_SRC);

  logic [1:0] sync1_q, sync2_q;   // {disabled, stopped}
  logic       stop_q, off_q;
  drive_e     drive;

  always_ff @(posedge clk_i) begin
    if (rst) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= {~oe, stop_req};
      sync2_q <= sync1_q;
    end
  end

  // Gate state changes only while the lane clock is low.
  always_ff @(negedge clk_i) begin
    if (rst) begin
      stop_q <= 1'b0;
      off_q  <= 1'b0;
    end else begin
      stop_q <= sync2_q[0];
      off_q  <= sync2_q[1];
    end
  end

  always_comb begin
    if (pd_active)
      drive = HAS_PD_TRI ? (pd_tri ? DRV_TRI : DRV_STATIC) : DRV_LOW;
    else if (off_q)
      drive = DRV_TRI;
    else if (stop_q)
      drive = HAS_STATIC_S ? (stop_tri ? DRV_TRI : DRV_STATIC) : DRV_LOW;
    else
      drive = DRV_RUN;
  end

  assign drive_o = drive;
  assign clk_o   = clk_i & ~stop_q & ~off_q & ~pd_active;

endmodule

// File: rtl/clk_stop_ctrl.sv
`timescale 1ns/1ps
module clk_stop_ctrl
  import clk_stop_pkg::*;
#(
  parameter int N_PCI  = 7,
  parameter int N_PCIF = 3,
  parameter int N_CPU  = 3,
  parameter int N_AUX  = 2,
  localparam int NL    = N_PCI + N_PCIF + 1 + N_CPU + N_AUX
) (
  input  logic            rst,
  input  logic [NL-1:0]   lane_clk_i,
  input  logic            pci_stop_n,
  input  logic            pwr_dn_n,
  input  logic            sw_stop_ctl,
  input  logic            stop_pin_mask,
  input  logic            pd_pin_mask,
  input  logic [NL-1:0]   lane_oe,
  input  logic [NL-1:0]   lane_stoppable,
  input  logic [NL-1:0]   stop_tri,
  input  logic [NL-1:0]   pd_tri,
  output logic [NL-1:0]   lane_clk_o,
  output logic [2*NL-1:0] lane_drive_o
);

  logic [NL-1:0] lane_stop;
  logic          pd_active;

  clk_stop_req #(
    .N_PCI (N_PCI),
    .N_PCIF(N_PCIF),
    .N_CPU (N_CPU),
    .N_AUX (N_AUX)
  ) u_req (
    .pci_stop_n    (pci_stop_n),
    .sw_stop_ctl   (sw_stop_ctl),
    .stop_pin_mask (stop_pin_mask),
    .pwr_dn_n      (pwr_dn_n),
    .pd_pin_mask   (pd_pin_mask),
    .lane_stoppable(lane_stoppable),
    .lane_stop     (lane_stop),
    .pd_active     (pd_active)
  );

  for (genvar i = 0; i < NL; i++) begin : g_lane
    clk_stop_lane #(
      .KIND(kind_of(i, N_PCI, N_PCIF, N_CPU))
    ) u_lane (
      .clk_i    (lane_clk_i[i]),
      .rst      (rst),
      .stop_req (lane_stop[i]),
      .oe       (lane_oe[i]),
      .stop_tri (stop_tri[i]),
      .pd_tri   (pd_tri[i]),
      .pd_active(pd_active),
      .clk_o    (lane_clk_o[i]),
      .drive_o  (lane_drive_o[2*i +: 2])
    );
  end

endmodule

// File: rtl/clk_stop_ctrl_chk.sv
`timescale 1ns/1ps
module clk_stop_ctrl_chk
  import clk_stop_pkg::*;
#(
  parameter int N_PCI  = 7,
  parameter int N_PCIF = 3,
  parameter int N_CPU  = 3,
  parameter int N_AUX  = 2,
  localparam int NL    = N_PCI + N_PCIF + 1 + N_CPU + N_AUX
) (
  input logic            rst,
  input logic [NL-1:0]   lane_clk_i,
  input logic            pwr_dn_n,
  input logic            pd_pin_mask,
  input logic [NL-1:0]   lane_clk_o,
  input logic [2*NL-1:0] lane_drive_o
);

  logic pd_seen;
  assign pd_seen = ~pwr_dn_n & ~pd_pin_mask;

  for (genvar i = 0; i < NL; i++) begin : g_chk
    localparam lane_kind_e K = kind_of(i, N_PCI, N_PCIF, N_CPU);
    logic [1:0] code;
    assign code = lane_drive_o[2*i +: 2];

    // R6: in power-down, no high level reaches the output during a high phase
    assert_pd_gates_clock_R6: assert property (
      @(negedge lane_clk_i[i]) disable iff (rst)
        pd_seen |-> !lane_clk_o[i]);

    // R8: a high output pulse only exists while the lane reports running
    assert_high_means_run_R8: assert property (
      @(negedge lane_clk_i[i]) disable iff (rst)
        lane_clk_o[i] |-> (code == 2'b00));

    if (K == LK_CPU || K == LK_AUX) begin : g_free
      // R9: processor and other lanes never report stopped low outside power-down
      assert_free_lane_R9: assert property (
        @(negedge lane_clk_i[i]) disable iff (rst)
          !pd_seen |-> (code != 2'b01));
    end

    if (K != LK_SRC && K != LK_CPU) begin : g_nostatic
      // R11: only the reference and processor lanes may report driven static
      assert_no_static_R11: assert property (
        @(negedge lane_clk_i[i]) disable iff (rst)
          code != 2'b10);
    end
  end

endmodule

bind clk_stop_ctrl clk_stop_ctrl_chk #(
  .N_PCI (N_PCI),
  .N_PCIF(N_PCIF),
  .N_CPU (N_CPU),
  .N_AUX (N_AUX)
) u_chk (
  .rst         (rst),
  .lane_clk_i  (lane_clk_i),
  .pwr_dn_n    (pwr_dn_n),
  .pd_pin_mask (pd_pin_mask),
  .lane_clk_o  (lane_clk_o),
  .lane_drive_o(lane_drive_o)
);

// File: tb/clk_stop_ctrl_bench.sv
`timescale 1ns/1ps
module clk_stop_ctrl_bench;

  localparam int NL      = 16;
  localparam int SRC_IDX = 10;

  logic            clk = 1'b0, clk10 = 1'b0, clk14 = 1'b0;
  logic            rst = 1'b1;
  logic [NL-1:0]   lane_clk;
  logic            pci_stop_n = 1'b1, pwr_dn_n = 1'b1, sw_stop_ctl = 1'b1;
  logic            stop_pin_mask = 1'b0, pd_pin_mask = 1'b0;
  logic [NL-1:0]   lane_oe = '1, lane_stoppable = '0, stop_tri = '0, pd_tri = '0;
  logic [NL-1:0]   lane_clk_o;
  logic [2*NL-1:0] lane_drive_o;

  always #4 clk   = ~clk;    // 125 MHz
  always #5 clk10 = ~clk10;
  always #7 clk14 = ~clk14;

  for (genvar g = 0; g < NL; g++) begin : g_clk
    assign lane_clk[g] = (g % 3 == 0) ? clk : ((g % 3 == 1) ? clk10 : clk14);
  end

  clk_stop_ctrl u_clk_stop_ctrl (
    .rst(rst), .lane_clk_i(lane_clk), .pci_stop_n(pci_stop_n), .pwr_dn_n(pwr_dn_n),
    .sw_stop_ctl(sw_stop_ctl), .stop_pin_mask(stop_pin_mask), .pd_pin_mask(pd_pin_mask),
    .lane_oe(lane_oe), .lane_stoppable(lane_stoppable), .stop_tri(stop_tri),
    .pd_tri(pd_tri), .lane_clk_o(lane_clk_o), .lane_drive_o(lane_drive_o)
  );

  int total = 0, failed = 0, issued = 0, mon_done = 0, short_cnt = 0;
  bit watch = 1'b0;
  realtime t_rise = 0.0;

  typedef struct {
    logic [2*NL-1:0] code;
    logic [NL-1:0]   act;
    string           tag;
  } sb_item_t;
  sb_item_t sb_q[$];

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Expected drive code of lane i from the requirements.
  function automatic logic [1:0] exp_code(input int i);
    bit pd      = !pwr_dn_n && !pd_pin_mask;
    bit req     = (!pci_stop_n && !stop_pin_mask) || !sw_stop_ctl;
    bit is_pci  = (i < 7);
    bit is_pcif = (i >= 7 && i <= 9);
    bit is_src  = (i == SRC_IDX);
    bit is_cpu  = (i >= 11 && i <= 13);
    if (pd) return (is_cpu || is_src) ? (pd_tri[i] ? 2'b11 : 2'b10) : 2'b01;
    if (!lane_oe[i]) return 2'b11;
    if (req && (is_pci || ((is_pcif || is_src) && lane_stoppable[i])))
      return is_src ? (stop_tri[i] ? 2'b11 : 2'b10) : 2'b01;
    return 2'b00;
  endfunction

  function automatic logic [2*NL-1:0] exp_vec();
    logic [2*NL-1:0] v;
    for (int i = 0; i < NL; i++) v[2*i +: 2] = exp_code(i);
    return v;
  endfunction

  function automatic logic [NL-1:0] act_vec(input logic [2*NL-1:0] v);
    logic [NL-1:0] a;
    for (int i = 0; i < NL; i++) a[i] = (v[2*i +: 2] == 2'b00);
    return a;
  endfunction

  // Driver: let the change settle, then hand the expectation to the monitor.
  task automatic run_case(input string tag);
    sb_item_t it;
    repeat (12) @(negedge clk);
    it.code = exp_vec();
    it.act  = act_vec(it.code);
    it.tag  = tag;
    issued++;
    sb_q.push_back(it);
    wait (mon_done == issued);
  endtask

  // Monitor: compare codes, then look for clock activity over 64 ns.
  initial begin
    forever begin
      sb_item_t it;
      logic [NL-1:0] seen;
      wait (sb_q.size() > 0);
      it = sb_q.pop_front();
      check(lane_drive_o == it.code, {it.tag, " drive codes"},
            64'(lane_drive_o), 64'(it.code));
      seen = '0;
      for (int s = 0; s < 64; s++) begin
        #1;
        seen = seen | lane_clk_o;
      end
      check(seen == it.act, {it.tag, " clock activity"}, 64'(seen), 64'(it.act));
      mon_done++;
    end
  end

  // R8: every high pulse on lane 0 spans a full 4 ns high phase.
  always @(posedge lane_clk_o[0]) t_rise = $realtime;
  always @(negedge lane_clk_o[0]) if (watch && ($realtime - t_rise) < 3.9) short_cnt++;

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  endtask

  initial begin
    #800000;
    total++;
    failed++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (10) @(negedge clk);
    rst = 1'b0;
    watch = 1'b1;
    run_case("R10 reset state");

    pci_stop_n = 1'b0;
    run_case("R1 R2 R3 R9 pin stop, no optional lanes");

    lane_stoppable[8] = 1'b1;
    lane_stoppable[SRC_IDX] = 1'b1;
    lane_stoppable[12] = 1'b1;   // no effect on a processor lane (R9)
    run_case("R2 R3 optional lanes follow stop, reference driven static");

    stop_tri[SRC_IDX] = 1'b1;
    run_case("R3 reference lane tristate on stop");

    pci_stop_n = 1'b1;
    run_case("R8 restart after release");

    sw_stop_ctl = 1'b0;
    run_case("R4 software stop control");
    sw_stop_ctl = 1'b1;

    stop_pin_mask = 1'b1;
    pci_stop_n = 1'b0;
    run_case("R5 stop pin masked");
    stop_pin_mask = 1'b0;

    lane_oe[2] = 1'b0;
    lane_oe[12] = 1'b0;
    run_case("R7 R11 disabled lanes over stop");

    pci_stop_n = 1'b1;
    lane_oe = '1;
    run_case("R8 R7 all lanes running again");
    watch = 1'b0;

    check(short_cnt == 0, "R8 no shortened high pulse", 64'(short_cnt), 64'd0);

    // R6: asynchronous power-down, checked 1 ns after the pin falls.
    pd_tri[11] = 1'b1;
    pd_tri[SRC_IDX] = 1'b0;
    @(negedge clk);
    pwr_dn_n = 1'b0;
    #1;
    check(lane_clk_o == '0, "R6 clocks low at once", 64'(lane_clk_o), 64'd0);
    check(lane_drive_o == exp_vec(), "R6 R11 power-down codes at once",
          64'(lane_drive_o), 64'(exp_vec()));
    lane_oe[3] = 1'b0;
    run_case("R6 R11 power-down over disable");

    pd_tri[SRC_IDX] = 1'b1;
    run_case("R6 reference lane tristate in power-down");

    pd_pin_mask = 1'b1;
    run_case("R5 power-down pin masked");

    pd_pin_mask = 1'b0;
    pwr_dn_n = 1'b1;
    lane_oe = '1;
    run_case("R10 R6 recovery after power-down");

    finish_run();
  end

endmodule